// File: doc/BRIEF.md
# Frame Position Strobe Tracker

This block follows the byte position on a byte-wide framer bus that marks each byte with strobes. A valid qualifier says whether the strobes on a byte mean anything. The strobes then mark the byte as payload, as fixed overhead or as path (embedded) overhead. A strobe is taken only on a qualified tick, which is a cycle where the clock enable is high and the valid qualifier is high. The clock enable lets one clock carry the single-rate bus with the enable always high. It also carries the 3x bus with the enable high one cycle in three, and the 12x bus with the enable high one cycle in twelve.

Software sets the enable input high to start a lock search. The block waits for the first path-overhead strobe and then declares sync. In sync it checks every row, where a row runs from one path-overhead strobe to the next. A row must span exactly 90 qualified ticks and contain exactly 84 payload ticks. A row that breaks this rule, or a byte marked as both payload and fixed overhead, sets a sticky corrupt flag and drops sync. Recovery needs software to take the enable low and then high again.

While locked, the block gives out one payload-slot pulse for each payload byte. It also drives that byte on its transmit data output. While disabled, the transmit output sits at an idle value of all ones.

Top module: `frame_strobe_tracker`

## Requirements
- R1: After reset, sync_o = 0, corrupt_o = 0, slot_o = 0 and tx_data_o = 8'hFF.
- R2: Strobes are taken only on a qualified tick (clk_en_i = 1 and val_i = 1). On any other cycle, no strobe value adds to a count, produces a slot or changes sync_o or corrupt_o.
- R3: While enable_i = 0, sync_o = 0, corrupt_o = 0, slot_o = 0 and tx_data_o = 8'hFF from the cycle after enable_i is sampled low.
- R4: Once enabled, sync_o stays 0 until the first qualified eoh_i and goes to 1 in the cycle after it. Payload ticks taken before sync produce no slot.
- R5: In sync, a qualified eoh_i that comes exactly 90 qualified ticks after the previous one, with exactly 84 qualified payload ticks between them, keeps sync_o = 1 and corrupt_o = 0.
- R6: In sync, any of the following sets corrupt_o = 1 and clears sync_o in the next cycle: an eoh_i with any other tick or payload count, a 90th qualified tick after eoh_i that carries no eoh_i, or a qualified tick with both pay_i and foh_i high.
- R7: corrupt_o is sticky while enable_i stays high. Rows that are well formed do not restore sync. Taking enable_i low clears the flag, and the next high level starts a new lock search.
- R8: For each qualified tick with pay_i = 1 and eoh_i = 0 taken in sync (and not itself corrupting), slot_o pulses for one cycle in the next cycle. In that cycle tx_data_o carries data_i from the tick, and it holds that value until the next slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | Clock enable that sets the byte rate |
| enable_i | input | 1 | Software enable; a low-to-high change restarts the lock search |
| val_i | input | 1 | Qualifier for the three position strobes |
| pay_i | input | 1 | Payload byte strobe |
| foh_i | input | 1 | Fixed overhead byte strobe |
| eoh_i | input | 1 | Path (embedded) overhead byte strobe |
| data_i | input | 8 | Payload byte to transmit |
| sync_o | output | 1 | Locked to path-overhead strobes |
| corrupt_o | output | 1 | Sticky malformed-pattern flag |
| slot_o | output | 1 | One-cycle pulse per payload byte taken in sync |
| tx_data_o | output | 8 | Transmit byte; 8'hFF while disabled |

## Verification
Checks on every cycle cover the following: the idle output while disabled, and slots occurring only in sync with the byte of the previous cycle. They also cover sync rising only after a qualified path-overhead strobe, the corrupt flag staying set and excluding sync, and that cycles which are not qualified leave the status unchanged. A bench scenario is needed for the row-length rules themselves: a full 90-tick row passing at two enable rates, and rows that are short, long or light on payload being caught. The bench also shows the flag holding across later rows that are well formed, the recovery through an enable toggle, and the exact order of transmitted bytes.

// File: rtl/fst_pkg.sv
package fst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_SYNC = 2'd2,
    ST_LOST = 2'd3
  } trk_state_e;
endpackage

// File: rtl/fst_strobe_decode.sv
module fst_strobe_decode (
  input  logic clk_en_i,
  input  logic val_i,
  input  logic pay_i,
  input  logic foh_i,
  input  logic eoh_i,
  output logic q_eoh_o,
  output logic q_tick_o,
  output logic q_pay_o,
  output logic q_clash_o
);
  logic q_any;
  assign q_any     = clk_en_i & val_i;
  assign q_eoh_o   = q_any & eoh_i;
  // path overhead wins over the other strobes on the same byte
  assign q_tick_o  = q_any & ~eoh_i;
  assign q_pay_o   = q_tick_o & pay_i;
  assign q_clash_o = q_tick_o & pay_i & foh_i;
endmodule

// File: rtl/fst_sat_counter.sv
module fst_sat_counter #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_o <= '0;
    else if (clr_i)                  cnt_o <= '0;
    else if (inc_i && cnt_o != MAX)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/fst_lock_fsm.sv
module fst_lock_fsm
  import fst_pkg::*;
#(
  parameter int CNT_W     = 7,
  parameter int ROW_TICKS = 90,
  parameter int ROW_PAY   = 84
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             q_eoh_i,
  input  logic             q_tick_i,
  input  logic             q_pay_i,
  input  logic             q_clash_i,
  input  logic [CNT_W-1:0] tick_cnt_i,
  input  logic [CNT_W-1:0] pay_cnt_i,
  output trk_state_e       state_o,
  output logic             take_o
);
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(ROW_TICKS - 1);
  localparam logic [CNT_W-1:0] PAY_CNT   = CNT_W'(ROW_PAY);

  trk_state_e state_q, state_d;
  logic row_ok, overdue, bad;

  assign row_ok  = (tick_cnt_i == LAST_TICK) && (pay_cnt_i == PAY_CNT);
  assign overdue = q_tick_i && (tick_cnt_i == LAST_TICK);
  assign bad     = (q_eoh_i && !row_ok) || overdue || q_clash_i;

  always_comb begin
    state_d = state_q;
    if (!enable_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: state_d = ST_HUNT;
        ST_HUNT: if (q_eoh_i) state_d = ST_SYNC;
        ST_SYNC: if (bad) state_d = ST_LOST;
        ST_LOST: state_d = ST_LOST;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
  assign take_o  = enable_i && (state_q == ST_SYNC) && q_pay_i && !overdue && !q_clash_i;
endmodule

// File: rtl/fst_tx_driver.sv
module fst_tx_driver #(
  parameter int              DATA_W    = 8,
  parameter logic [DATA_W-1:0] IDLE_BYTE = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              take_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              slot_o,
  output logic [DATA_W-1:0] tx_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_o    <= 1'b0;
      tx_data_o <= IDLE_BYTE;
    end else if (!enable_i) begin
      slot_o    <= 1'b0;
      tx_data_o <= IDLE_BYTE;
    end else begin
      slot_o <= take_i;
      if (take_i) tx_data_o <= data_i;
    end
  end
endmodule

// File: rtl/frame_strobe_tracker.sv
module frame_strobe_tracker
  import fst_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 7,
  parameter int ROW_TICKS = 90,
  parameter int ROW_PAY   = 84
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_i,
  input  logic              enable_i,
  input  logic              val_i,
  input  logic              pay_i,
  input  logic              foh_i,
  input  logic              eoh_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              sync_o,
  output logic              corrupt_o,
  output logic              slot_o,
  output logic [DATA_W-1:0] tx_data_o
);
  localparam logic [DATA_W-1:0] IDLE_BYTE = {DATA_W{1'b1}};

  logic q_eoh, q_tick, q_pay, q_clash, take, cnt_clr;
  logic [CNT_W-1:0] tick_cnt, pay_cnt;
  trk_state_e state;

  fst_strobe_decode u_dec (
    .clk_en_i (clk_en_i),
    .val_i    (val_i),
    .pay_i    (pay_i),
    .foh_i    (foh_i),
    .eoh_i    (eoh_i),
    .q_eoh_o  (q_eoh),
    .q_tick_o (q_tick),
    .q_pay_o  (q_pay),
    .q_clash_o(q_clash)
  );

  assign cnt_clr = q_eoh | ~enable_i;

  fst_sat_counter #(.W(CNT_W)) u_tick_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .inc_i (q_tick),
    .cnt_o (tick_cnt)
  );

  fst_sat_counter #(.W(CNT_W)) u_pay_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .inc_i (q_pay),
    .cnt_o (pay_cnt)
  );

  fst_lock_fsm #(
    .CNT_W    (CNT_W),
    .ROW_TICKS(ROW_TICKS),
    .ROW_PAY  (ROW_PAY)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enable_i  (enable_i),
    .q_eoh_i   (q_eoh),
    .q_tick_i  (q_tick),
    .q_pay_i   (q_pay),
    .q_clash_i (q_clash),
    .tick_cnt_i(tick_cnt),
    .pay_cnt_i (pay_cnt),
    .state_o   (state),
    .take_o    (take)
  );

  fst_tx_driver #(
    .DATA_W   (DATA_W),
    .IDLE_BYTE(IDLE_BYTE)
  ) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .take_i   (take),
    .data_i   (data_i),
    .slot_o   (slot_o),
    .tx_data_o(tx_data_o)
  );

  assign sync_o    = (state == ST_SYNC);
  assign corrupt_o = (state == ST_LOST);
endmodule

// File: rtl/fst_checker.sv
module fst_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clk_en_i,
  input logic              enable_i,
  input logic              val_i,
  input logic              pay_i,
  input logic              foh_i,
  input logic              eoh_i,
  input logic [DATA_W-1:0] data_i,
  input logic              sync_o,
  input logic              corrupt_o,
  input logic              slot_o,
  input logic [DATA_W-1:0] tx_data_o
);
  // R3
  idle_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!sync_o && !corrupt_o && !slot_o && tx_data_o == {DATA_W{1'b1}}));

  // R2
  unqualified_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !(clk_en_i && val_i)) |=> (!slot_o && $stable(sync_o) && $stable(corrupt_o)));

  // R4
  lock_on_eoh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> $past(clk_en_i && val_i && eoh_i && enable_i));

  // R6
  clash_flagged_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && sync_o && clk_en_i && val_i && pay_i && foh_i && !eoh_i) |=> corrupt_o);

  // R7
  corrupt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (corrupt_o && enable_i) |=> corrupt_o);

  // R7
  corrupt_excludes_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corrupt_o |-> !sync_o);

  // R8
  slot_in_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_o |-> (sync_o && tx_data_o == $past(data_i)));
endmodule

bind frame_strobe_tracker fst_checker #(.DATA_W(DATA_W)) u_fst_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clk_en_i (clk_en_i),
  .enable_i (enable_i),
  .val_i    (val_i),
  .pay_i    (pay_i),
  .foh_i    (foh_i),
  .eoh_i    (eoh_i),
  .data_i   (data_i),
  .sync_o   (sync_o),
  .corrupt_o(corrupt_o),
  .slot_o   (slot_o),
  .tx_data_o(tx_data_o)
);

// File: tb/frame_strobe_tracker_test.sv
module frame_strobe_tracker_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic clk_en_i = 1'b0, enable_i = 1'b0, val_i = 1'b0;
  logic pay_i = 1'b0, foh_i = 1'b0, eoh_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic sync_o, corrupt_o, slot_o;
  logic [7:0] tx_data_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  logic [7:0] seq = 8'h00;

  always #2.5 clk = ~clk;

  frame_strobe_tracker uut (
    .clk_i(clk), .rst_ni(rst_ni), .clk_en_i(clk_en_i), .enable_i(enable_i),
    .val_i(val_i), .pay_i(pay_i), .foh_i(foh_i), .eoh_i(eoh_i), .data_i(data_i),
    .sync_o(sync_o), .corrupt_o(corrupt_o), .slot_o(slot_o), .tx_data_o(tx_data_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: each slot pops one expected byte (R8, R4)
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_ni && slot_o) begin
        if (exp_q.size() == 0) begin
          check("R8 unexpected slot", 32'd1, 32'd0);
        end else begin
          check("R8 slot byte", {24'd0, tx_data_o}, {24'd0, exp_q.pop_front()});
        end
      end
    end
  end

  // one qualified tick after gap junk cycles with clk_en low
  task automatic qtick(input logic v, input logic p, input logic f, input logic e,
                       input bit exp_slot, input int gap);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      clk_en_i = 1'b0; val_i = 1'b1; pay_i = 1'b1; foh_i = 1'b1; eoh_i = 1'b1;
      data_i = 8'hA5;
      @(posedge clk); #1;
    end
    @(negedge clk);
    seq = seq + 8'd1;
    clk_en_i = 1'b1; val_i = v; pay_i = p; foh_i = f; eoh_i = e; data_i = seq;
    if (exp_slot) exp_q.push_back(seq);
    @(posedge clk); #1;
  endtask

  task automatic body(input int npay, input int nfoh, input bit exp_slot, input int gap);
    for (int i = 0; i < npay; i++) qtick(1'b1, 1'b1, 1'b0, 1'b0, exp_slot, gap);
    for (int i = 0; i < nfoh; i++) qtick(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, gap);
  endtask

  task automatic set_en(input logic v);
    @(negedge clk);
    enable_i = v; clk_en_i = 1'b1; val_i = 1'b0; pay_i = 1'b0; foh_i = 1'b0; eoh_i = 1'b0;
    @(posedge clk); #1;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 sync", {31'd0, sync_o}, 32'd0);
    check("R1 corrupt", {31'd0, corrupt_o}, 32'd0);
    check("R1 slot", {31'd0, slot_o}, 32'd0);
    check("R1 tx", {24'd0, tx_data_o}, 32'hFF);
    @(negedge clk);
    rst_ni = 1'b1;

    // R3: disabled, full row is ignored
    qtick(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 0);
    body(84, 5, 1'b0, 0);
    qtick(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 0);
    check("R3 sync off", {31'd0, sync_o}, 32'd0);
    check("R3 tx idle", {24'd0, tx_data_o}, 32'hFF);

    // R4: hunt, then lock
    set_en(1'b1);
    body(10, 2, 1'b0, 0);
    check("R4 no sync before eoh", {31'd0, sync_o}, 32'd0);
    check("R4 tx idle in hunt", {24'd0, tx_data_o}, 32'hFF);
    qtick(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 0);
    check("R4 sync after eoh", {31'd0, sync_o}, 32'd1);

    // R5 / R8 at full rate
    body(84, 5, 1'b1, 0);
    qtick(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 0);
    check("R5 row ok sync", {31'd0, sync_o}, 32'd1);
    check("R5 row ok corrupt", {31'd0, corrupt_o}, 32'd0);

    // R2: unqualified strobes do not count; row at 1-in-3 rate
    qtick(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 0);
    qtick(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 0);
    body(84, 5, 1'b1, 2);
    qtick(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2);
    check("R2 ignored strobes sync", {31'd0, sync_o}, 32'd1);
    check("R2 ignored strobes corrupt", {31'd0, corrupt_o}, 32'd0);

    // R6: payload and fixed overhead together
    body(3, 0, 1'b1, 0);
    qtick(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 0);
    check("R6 clash corrupt", {31'd0, corrupt_o}, 32'd1);
    check("R6 clash sync", {31'd0, sync_o}, 32'd0);

    // R7: good rows do not restore
    body(80, 5, 1'b0, 0);
    qtick(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 0);
    body(84, 5, 1'b0, 0);
    qtick(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 0);
    check("R7 sticky corrupt", {31'd0, corrupt_o}, 32'd1);
    check("R7 no relock", {31'd0, sync_o}, 32'd0);
    set_en(1'b0);
    check("R7 cleared by disable", {31'd0, corrupt_o}, 32'd0);
    check("R3 tx idle again", {24'd0, tx_data_o}, 32'hFF);
    set_en(1'b1);
    check("R7 hunt after enable", {31'd0, sync_o}, 32'd0);
    qtick(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 0);
    check("R7 relock", {31'd0, sync_o}, 32'd1);

    // R6: short row
    body(84, 4, 1'b1, 0);
    qtick(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 0);
    check("R6 short row", {31'd0, corrupt_o}, 32'd1);

    // R6: overdue eoh
    set_en(1'b0);
    set_en(1'b1);
    qtick(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 0);
    body(84, 5, 1'b1, 0);
    check("R6 89 ticks still sync", {31'd0, sync_o}, 32'd1);
    qtick(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 0);
    check("R6 overdue corrupt", {31'd0, corrupt_o}, 32'd1);

    // R6: right length, wrong payload count
    set_en(1'b0);
    set_en(1'b1);
    qtick(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 0);
    body(83, 6, 1'b1, 0);
    qtick(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 0);
    check("R6 payload count corrupt", {31'd0, corrupt_o}, 32'd1);
    check("R6 payload count sync", {31'd0, sync_o}, 32'd0);

    set_en(1'b0);
    repeat (2) @(posedge clk);
    #1;
    check("R8 all slots seen", exp_q.size(), 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule